// File: doc/BRIEF.md
# Ordered Store Buffer with Load Forwarding

This block sits between a core's retirement stage and its first-level data cache. Each retired store arrives with a doubleword address, an eight-lane byte mask and 64 bits of data. The block holds it in an in-order queue and writes the queue out, oldest first, through a valid/ready write port. Stores therefore reach memory in program order. A later load does not have to wait for them, so loads may complete ahead of earlier stores to other addresses.

Loads probe the queue while the cache is read. Every byte lane that a queued store covers is taken from the youngest such store. The other lanes come from the cache. The merged doubleword is returned one cycle after the load is accepted. A load can therefore read its own thread's stores before other agents see them.

A barrier request (a fence, or the load half of an atomic read-modify-write) is held off until the queue is empty and no store is being offered. While a barrier waits, no load is accepted. Back-pressure works as follows:
- The store input stalls only when all entries are occupied.
- The write port keeps its entry stable until the cache accepts it.
- The load port stalls only behind a pending barrier.

The depth must be a power of two.

Top module: `store_buffer_tso`

## Requirements
- R1: After reset the queue is empty: `st_ready`=1, `dr_valid`=0, `ld_rsp_valid`=0, and `bar_ready`=1 while `st_valid` is low.
- R2: Accepted stores appear on the write port in acceptance order. Each appears exactly once, and an entry leaves only in a cycle where `dr_valid` and `dr_ready` are both high.
- R3: While `dr_valid` is high and `dr_ready` low, `dr_valid`, `dr_addr`, `dr_be` and `dr_data` hold their values into the next cycle.
- R4: With DEPTH (8) entries held, `st_ready` is low. It returns high after an entry drains.
- R5: `ld_rsp_valid` is high exactly in the cycle after a cycle with `ld_valid`=1 and `ld_ready`=1. `cache_rdata` is sampled in that response cycle.
- R6: A load whose address matches no queued entry returns `cache_rdata` unchanged, even when stores to other addresses are still queued.
- R7: A load to a doubleword fully written by a queued store returns the queued data, not the cache value.
- R8: Byte lane b of the response (bits 8b+7..8b) comes from the queue when a queued entry with the same address has mask bit b set. Otherwise it comes from the cache.
- R9: When several queued entries write the same lane of the same address, the lane is taken from the most recently accepted one.
- R10: A store accepted in the same cycle as a load is not seen by that load.
- R11: `bar_ready` is high only when the queue is empty and `st_valid` is low. It stays low while any entry is queued.
- R12: While `bar_valid` is high, `ld_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Retired store offered |
| st_ready | output | 1 | Queue has room |
| st_addr | input | 29 | Store doubleword address |
| st_be | input | 8 | Store byte-lane mask |
| st_data | input | 64 | Store data |
| dr_valid | output | 1 | Oldest entry offered to cache |
| dr_ready | input | 1 | Cache accepts write |
| dr_addr | output | 29 | Write doubleword address |
| dr_be | output | 8 | Write byte-lane mask |
| dr_data | output | 64 | Write data |
| ld_valid | input | 1 | Load request |
| ld_ready | output | 1 | Load accepted |
| ld_addr | input | 29 | Load doubleword address |
| cache_rd_en | output | 1 | Cache read strobe (load accepted) |
| cache_rd_addr | output | 29 | Cache read address |
| cache_rdata | input | 64 | Cache read data, valid in the response cycle |
| ld_rsp_valid | output | 1 | Load result valid |
| ld_rsp_data | output | 64 | Merged load result |
| bar_valid | input | 1 | Fence or atomic requests ordering |
| bar_ready | output | 1 | Ordering point reached |

## Verification
The assertions check the per-cycle rules on every cycle:
- the fixed one-cycle load response;
- the write port holding its entry under stall;
- no push into a full queue and no pop from an empty one;
- loads blocked behind a pending barrier;
- an empty queue right after a barrier is granted;
- forwarded lanes backed by a live entry.

Only the scenarios can show the data behaviour. They cover program-order draining, youngest-store priority on overlapping lanes, the per-byte mix of queued and cache data, and the invisibility of a same-cycle store. A reference queue in the bench predicts every drained write and every load result for both the directed and the randomized traffic.

// File: rtl/sb_pkg.sv
package sb_pkg;
  parameter int ADDR_W = 29;
  parameter int DATA_W = 64;
  parameter int BE_W   = DATA_W / 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [BE_W-1:0]   be;
    logic [DATA_W-1:0] data;
  } sb_entry_t;
endpackage

// File: rtl/sb_queue.sv
module sb_queue #(
  parameter int DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  sb_pkg::sb_entry_t     push_ent,
  input  logic                  pop,
  output logic                  full,
  output logic                  empty,
  output logic [DEPTH-1:0]      age_vld,
  output sb_pkg::sb_entry_t     age_ent [DEPTH]
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  sb_pkg::sb_entry_t mem [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] cnt;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  always_ff @(posedge clk) begin
    if (push) mem[tail] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (push) tail <= tail + 1'b1;
      if (pop)  head <= head + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // age-ordered view: slot 0 is the oldest entry
  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    logic [PW-1:0] idx;
    assign idx        = head + PW'(k);
    assign age_ent[k] = mem[idx];
    assign age_vld[k] = (CW'(k) < cnt);
  end

  // R4
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R2
  no_pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/sb_fwd.sv
module sb_fwd #(
  parameter int DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DEPTH-1:0]              age_vld,
  input  sb_pkg::sb_entry_t             age_ent [DEPTH],
  input  logic [sb_pkg::ADDR_W-1:0]     lk_addr,
  output logic [sb_pkg::BE_W-1:0]       hit_mask,
  output logic [sb_pkg::DATA_W-1:0]     hit_data
);
  localparam int NB = sb_pkg::BE_W;

  logic [DEPTH-1:0] addr_hit;

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    assign addr_hit[k] = age_vld[k] && (age_ent[k].addr == lk_addr);
  end

  // per lane: scan oldest to youngest, the last match wins
  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic       lane_m;
    logic [7:0] lane_d;
    always_comb begin
      lane_m = 1'b0;
      lane_d = '0;
      for (int k = 0; k < DEPTH; k++) begin
        if (addr_hit[k] && age_ent[k].be[b]) begin
          lane_m = 1'b1;
          lane_d = age_ent[k].data[b*8 +: 8];
        end
      end
    end
    assign hit_mask[b]         = lane_m;
    assign hit_data[b*8 +: 8]  = lane_d;
  end

  // R8
  fwd_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_mask) |-> (|age_vld));
endmodule

// File: rtl/sb_order_gate.sv
module sb_order_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic bar_valid,
  input  logic q_empty,
  input  logic st_valid,
  input  logic ld_valid,
  output logic bar_ready,
  output logic ld_ready,
  output logic ld_fire
);
  assign bar_ready = q_empty && !st_valid;
  assign ld_ready  = !bar_valid;
  assign ld_fire   = ld_valid && ld_ready;

  // R11
  bar_grant_leaves_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_valid && bar_ready) |=> q_empty);
  // R12
  no_load_past_barrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bar_valid |-> !ld_fire);
endmodule

// File: rtl/store_buffer_tso.sv
module store_buffer_tso #(
  parameter int DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        st_valid,
  output logic                        st_ready,
  input  logic [sb_pkg::ADDR_W-1:0]   st_addr,
  input  logic [sb_pkg::BE_W-1:0]     st_be,
  input  logic [sb_pkg::DATA_W-1:0]   st_data,
  output logic                        dr_valid,
  input  logic                        dr_ready,
  output logic [sb_pkg::ADDR_W-1:0]   dr_addr,
  output logic [sb_pkg::BE_W-1:0]     dr_be,
  output logic [sb_pkg::DATA_W-1:0]   dr_data,
  input  logic                        ld_valid,
  output logic                        ld_ready,
  input  logic [sb_pkg::ADDR_W-1:0]   ld_addr,
  output logic                        cache_rd_en,
  output logic [sb_pkg::ADDR_W-1:0]   cache_rd_addr,
  input  logic [sb_pkg::DATA_W-1:0]   cache_rdata,
  output logic                        ld_rsp_valid,
  output logic [sb_pkg::DATA_W-1:0]   ld_rsp_data,
  input  logic                        bar_valid,
  output logic                        bar_ready
);
  localparam int NB = sb_pkg::BE_W;
  localparam int DW = sb_pkg::DATA_W;

  logic                 q_full, q_empty, push, pop, ld_fire;
  logic [DEPTH-1:0]     age_vld;
  sb_pkg::sb_entry_t    age_ent [DEPTH];
  sb_pkg::sb_entry_t    in_ent;
  logic [NB-1:0]        hit_mask, mask_q;
  logic [DW-1:0]        hit_data, data_q;
  logic                 rsp_q;

  assign in_ent   = '{addr: st_addr, be: st_be, data: st_data};
  assign st_ready = !q_full;
  assign push     = st_valid && st_ready;
  assign dr_valid = !q_empty;
  assign pop      = dr_valid && dr_ready;
  assign dr_addr  = age_ent[0].addr;
  assign dr_be    = age_ent[0].be;
  assign dr_data  = age_ent[0].data;

  sb_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(push), .push_ent(in_ent), .pop(pop),
    .full(q_full), .empty(q_empty), .age_vld(age_vld), .age_ent(age_ent)
  );

  sb_fwd #(.DEPTH(DEPTH)) u_fwd (
    .clk(clk), .rst_n(rst_n), .age_vld(age_vld), .age_ent(age_ent),
    .lk_addr(ld_addr), .hit_mask(hit_mask), .hit_data(hit_data)
  );

  sb_order_gate u_gate (
    .clk(clk), .rst_n(rst_n), .bar_valid(bar_valid), .q_empty(q_empty),
    .st_valid(st_valid), .ld_valid(ld_valid), .bar_ready(bar_ready),
    .ld_ready(ld_ready), .ld_fire(ld_fire)
  );

  assign cache_rd_en   = ld_fire;
  assign cache_rd_addr = ld_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q  <= 1'b0;
      mask_q <= '0;
      data_q <= '0;
    end else begin
      rsp_q <= ld_fire;
      if (ld_fire) begin
        mask_q <= hit_mask;
        data_q <= hit_data;
      end
    end
  end

  assign ld_rsp_valid = rsp_q;

  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign ld_rsp_data[b*8 +: 8] = mask_q[b] ? data_q[b*8 +: 8] : cache_rdata[b*8 +: 8];
  end

  // R5
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> ld_rsp_valid);
  // R5
  no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_valid && ld_ready) |=> !ld_rsp_valid);
  // R3
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_addr) && $stable(dr_be) && $stable(dr_data)));
  // R11
  bar_waits_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bar_ready |-> (!dr_valid && !st_valid));
endmodule

// File: tb/sim_store_buffer_tso.sv
module sim_store_buffer_tso;
  localparam int CLK_PERIOD = 10;
  localparam int AW = sb_pkg::ADDR_W;
  localparam int DW = sb_pkg::DATA_W;
  localparam int NB = sb_pkg::BE_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 0, ld_valid = 0, bar_valid = 0, dr_ready;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [NB-1:0] st_be = '0;
  logic [DW-1:0] st_data = '0;
  logic st_ready, dr_valid, ld_ready, cache_rd_en, ld_rsp_valid, bar_ready;
  logic [AW-1:0] dr_addr, cache_rd_addr, c_addr;
  logic [NB-1:0] dr_be;
  logic [DW-1:0] dr_data, cache_rdata, ld_rsp_data;

  int n_vec = 0, n_fail = 0, dr_mode = 0;
  string ld_tag = "R6";
  sb_pkg::sb_entry_t mq[$];
  logic [DW-1:0] exp_ld[$];
  string exp_tag[$];
  logic pend_rsp = 0, hold_prev = 0;
  sb_pkg::sb_entry_t prev_dr;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_buffer_tso u0 (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_be(st_be), .st_data(st_data), .dr_valid(dr_valid),
    .dr_ready(dr_ready), .dr_addr(dr_addr), .dr_be(dr_be), .dr_data(dr_data),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .cache_rd_en(cache_rd_en), .cache_rd_addr(cache_rd_addr), .cache_rdata(cache_rdata),
    .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data),
    .bar_valid(bar_valid), .bar_ready(bar_ready)
  );

  function automatic logic [DW-1:0] cfun(input logic [AW-1:0] a);
    logic [DW-1:0] r;
    for (int b = 0; b < NB; b++) r[b*8 +: 8] = a[7:0] * 8'd7 + 8'(b * 29) + 8'h3C;
    return r;
  endfunction

  function automatic logic [DW-1:0] ref_load(input logic [AW-1:0] a);
    logic [DW-1:0] r = cfun(a);
    foreach (mq[i])
      if (mq[i].addr == a)
        for (int b = 0; b < NB; b++)
          if (mq[i].be[b]) r[b*8 +: 8] = mq[i].data[b*8 +: 8];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // cache model: data for the address read in the previous cycle
  always @(posedge clk) if (cache_rd_en) c_addr <= cache_rd_addr;
  assign cache_rdata = cfun(c_addr);

  always @(posedge clk) begin
    #1;
    case (dr_mode)
      0: dr_ready = 1'b0;
      1: dr_ready = 1'b1;
      default: dr_ready = ($urandom % 3) != 0;
    endcase
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_rsp) begin
        chk("R5 response cycle", {63'd0, ld_rsp_valid}, 64'd1);
        if (ld_rsp_valid && exp_ld.size() > 0)
          chk(exp_tag.pop_front(), ld_rsp_data, exp_ld.pop_front());
      end else if (ld_rsp_valid) chk("R5 stray response", 64'd1, 64'd0);
      pend_rsp = ld_valid && ld_ready;
      if (pend_rsp) begin
        exp_ld.push_back(ref_load(ld_addr));
        exp_tag.push_back(ld_tag);
      end
      if (hold_prev) begin
        chk("R3 hold valid", {63'd0, dr_valid}, 64'd1);
        chk("R3 hold entry", {dr_addr, dr_be} ^ {prev_dr.addr, prev_dr.be}, 64'd0);
        chk("R3 hold data", dr_data, prev_dr.data);
      end
      if (dr_valid && dr_ready) begin
        if (mq.size() == 0) chk("R2 drain with nothing queued", 64'd1, 64'd0);
        else begin
          chk("R2 drain address", 64'(dr_addr), 64'(mq[0].addr));
          chk("R2 drain mask", 64'(dr_be), 64'(mq[0].be));
          chk("R2 drain data", dr_data, mq[0].data);
          void'(mq.pop_front());
        end
      end
      if (st_valid && st_ready) mq.push_back('{addr: st_addr, be: st_be, data: st_data});
      hold_prev = dr_valid && !dr_ready;
      prev_dr = '{addr: dr_addr, be: dr_be, data: dr_data};
    end
  end

  task automatic do_store(input logic [AW-1:0] a, input logic [NB-1:0] be, input logic [DW-1:0] d);
    st_addr = a; st_be = be; st_data = d; st_valid = 1'b1;
    forever begin @(negedge clk); if (st_ready) break; end
    @(posedge clk); #1 st_valid = 1'b0;
  endtask

  task automatic do_load(input string tag, input logic [AW-1:0] a);
    ld_tag = tag; ld_addr = a; ld_valid = 1'b1;
    forever begin @(negedge clk); if (ld_ready) break; end
    @(posedge clk); #1 ld_valid = 1'b0;
  endtask

  task automatic wait_empty();
    forever begin @(negedge clk); if (!dr_valid) break; end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 st_ready", {63'd0, st_ready}, 64'd1);
    chk("R1 dr_valid", {63'd0, dr_valid}, 64'd0);
    chk("R1 ld_rsp_valid", {63'd0, ld_rsp_valid}, 64'd0);
    chk("R1 bar_ready", {63'd0, bar_ready}, 64'd1);
    @(posedge clk); #1;

    do_store(29'h10, 8'hFF, 64'h1111_2222_3333_4444);
    do_store(29'h20, 8'hFF, 64'hAAAA_BBBB_CCCC_DDDD);
    do_load("R6 miss passes queued stores", 29'h30);
    do_load("R7 full overlap", 29'h10);
    do_store(29'h10, 8'h0F, 64'h9999_8888_7777_6666);
    do_load("R9 youngest lanes", 29'h10);
    do_store(29'h40, 8'h3C, 64'hDEAD_BEEF_CAFE_F00D);
    do_load("R8 partial merge", 29'h40);

    // R10: store and load to the same address in one cycle
    st_addr = 29'h50; st_be = 8'hFF; st_data = 64'h0123_4567_89AB_CDEF; st_valid = 1'b1;
    ld_tag = "R10 same-cycle store unseen"; ld_addr = 29'h50; ld_valid = 1'b1;
    @(posedge clk); #1 st_valid = 1'b0; ld_valid = 1'b0;
    do_load("R7 store now visible", 29'h50);

    do_store(29'h60, 8'h01, 64'h11);
    do_store(29'h61, 8'h80, 64'h22 << 56);
    do_store(29'h62, 8'hF0, 64'h3333_4444_0000_0000);
    @(negedge clk);
    chk("R4 full blocks store", {63'd0, st_ready}, 64'd0);

    @(posedge clk); #1 bar_valid = 1'b1;
    @(negedge clk);
    chk("R11 barrier held with entries", {63'd0, bar_ready}, 64'd0);
    chk("R12 load blocked by barrier", {63'd0, ld_ready}, 64'd1 ^ 64'd1);
    dr_mode = 1;
    @(negedge clk); @(negedge clk);
    chk("R4 room after drain", {63'd0, st_ready}, 64'd1);
    wait_empty();
    chk("R11 barrier granted when empty", {63'd0, bar_ready}, 64'd1);
    @(posedge clk); #1;
    st_addr = 29'h70; st_be = 8'hFF; st_data = 64'h5; st_valid = 1'b1;
    @(negedge clk);
    chk("R11 offered store holds barrier", {63'd0, bar_ready}, 64'd0);
    @(posedge clk); #1 st_valid = 1'b0;
    wait_empty();
    chk("R11 barrier after store drained", {63'd0, bar_ready}, 64'd1);
    @(posedge clk); #1 bar_valid = 1'b0;

    dr_mode = 2;
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom % 4);
      if (($urandom % 2) == 0)
        do_store(a, NB'($urandom % 255 + 1), {$urandom, $urandom});
      else
        do_load("R8 random merge", a);
    end

    dr_mode = 1;
    wait_empty();
    repeat (3) @(negedge clk);
    chk("R2 all stores drained", 64'(mq.size()), 64'd0);
    chk("R5 all loads answered", 64'(exp_ld.size()), 64'd0);
    finish_run();
  end
endmodule